// File: doc/BRIEF.md
# Slow-Domain Register Write Bridge

This block accepts register writes on a fast bus clock and delivers them, one at a time, into a slow low-power clock domain. That domain's register file is modelled here as a plain sink strobe. A status word on the bus side shows how each transfer is progressing: a busy flag, a ready-for-next flag, a completion flag that clears itself when software reads it, and a sticky error flag. It also carries two power-up validity flags.

One register, the interrupt-enable register, lives entirely in the bus domain. Writes to it take effect at once, never enter the slow path and never raise completion. Every other address, including the status register itself, crosses the domain boundary. The crossing uses a toggle request and a toggle acknowledge, each passed through a multi-flop synchronizer. The address and data are held stable until the acknowledge returns. Software drives the bridge by writing, then polling status or waiting for the interrupt, and it clears error and validity flags by writing ones to their positions in the status register.

Top module: `lpw_bridge`

## Requirements
- R1: After reset, the status register (word address STAT_ADDR, default 5) reads 0x202: write-next (bit 9) and non-valid (bit 1) are set, and every other bit is 0, including the reserved alarm position at bit 4. The interrupt-enable register (IEN_ADDR, default 6) reads 0, and irq is low.
- R2: Each accepted write to any address other than IEN_ADDR produces exactly one sink_valid strobe in the slow domain, carrying the same address and data.
- R3: From the accepting edge until the acknowledge returns, write-busy (bit 10) reads 1 and write-next (bit 9) reads 0. In the same cycle that busy falls, write-complete (bit 8) becomes 1. Write-complete is set only by such a completion.
- R4: A read of the status register clears write-complete, so the next read returns bit 8 as 0. A completion in the same cycle as the read takes priority, and the flag stays set.
- R5: A write to IEN_ADDR updates the enables (write-next bit 9, write-complete bit 8, write-error bit 7) on the next edge. It is accepted even while a transfer is busy, sets no write-complete and produces no sink strobe.
- R6: A write to a non-IEN address while busy is dropped, with no sink strobe, and sets write-error (bit 7).
- R7: Write-error stays set until a status-register write with bit 7 at one completes through the slow path. Other completed writes leave it set.
- R8: An accepted status write with bits 1 and 0 at one clears non-valid and security-violation when it completes. A pulse on viol_i sets security-violation (bit 0).
- R9: irq equals (enable8 and (write-complete or write-error)) or (enable7 and write-error) or (enable9 and write-next).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-domain clock |
| bus_rst_n | input | 1 | Bus-domain synchronous reset, active low |
| lp_clk | input | 1 | Low-power-domain clock |
| lp_rst_n | input | 1 | Low-power-domain synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| viol_i | input | 1 | Security-violation event pulse |
| rdata | output | DATA_W | Read data, registered on the read edge |
| irq | output | 1 | Interrupt request |
| sink_valid | output | 1 | One-cycle strobe of a write landing in the slow domain |
| sink_addr | output | ADDR_W | Address of the landed write |
| sink_data | output | DATA_W | Data of the landed write |

## Verification
Several properties are checked on every clock of their own domain. The bridge never launches while a transfer is outstanding, and the held data stays still while busy. Each landed write gives a single-cycle strobe, a write that collides with a busy transfer always raises the error flag, completion rises only after a returned acknowledge, and a status read clears completion unless a completion arrives in the same cycle. Other behaviour can only be shown by the bench's scenarios. These are the end-to-end matching of sink contents to accepted writes, the immediate effect of enable writes during a busy transfer, the stickiness of the error flag across unrelated writes, the clearing of the validity flags and the resulting interrupt level.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
   // status and enable bit positions; software decodes these
   localparam int BIT_WBF = 10;
   localparam int BIT_WNF = 9;
   localparam int BIT_WCF = 8;
   localparam int BIT_WEF = 7;
   localparam int BIT_ALM = 4;
   localparam int BIT_NVF = 1;
   localparam int BIT_SVF = 0;
   localparam int STAT_MIN_W = BIT_WBF + 1;

   // flags a pending status write will clear when it completes
   typedef struct packed {
      logic wef;
      logic nvf;
      logic svf;
   } clr_mask_t;
endpackage

// File: rtl/lpw_sync.sv
module lpw_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lpw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[0], d};
         end
      end else begin : g_deep
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/lpw_src.sv
module lpw_src #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   input  logic              ack_tgl_i,
   output logic              req_tgl_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              busy_o,
   output logic              done_o
);
   logic ack_s;
   logic ack_d;
   logic req_tgl;
   logic [ADDR_W-1:0] hold_addr;
   logic [DATA_W-1:0] hold_data;

   lpw_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ack_tgl_i),
      .q     (ack_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_tgl   <= 1'b0;
         ack_d     <= 1'b0;
         hold_addr <= '0;
         hold_data <= '0;
      end else begin
         ack_d <= ack_s;
         if (launch) begin
            req_tgl   <= ~req_tgl;
            hold_addr <= addr_in;
            hold_data <= data_in;
         end
      end
   end

   assign req_tgl_o = req_tgl;
   assign addr_o    = hold_addr;
   assign data_o    = hold_data;
   assign busy_o    = req_tgl ^ ack_s;
   assign done_o    = ack_s ^ ack_d;

   // the owner must never start a transfer while one is outstanding
   assert_launch_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> !busy_o);

   // the crossing data must not move while the far side may sample it
   assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !launch) |=> ($stable(hold_data) && $stable(hold_addr)));
endmodule

// File: rtl/lpw_dst.sv
module lpw_dst #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_tgl_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              valid_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              ack_tgl_o
);
   logic req_s;
   logic seen;
   logic valid;
   logic [ADDR_W-1:0] cap_addr;
   logic [DATA_W-1:0] cap_data;

   lpw_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_req_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (req_tgl_i),
      .q     (req_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen     <= 1'b0;
         valid    <= 1'b0;
         cap_addr <= '0;
         cap_data <= '0;
      end else if (req_s != seen) begin
         seen     <= req_s;
         valid    <= 1'b1;
         cap_addr <= addr_i;
         cap_data <= data_i;
      end else begin
         valid <= 1'b0;
      end
   end

   assign valid_o   = valid;
   assign addr_o    = cap_addr;
   assign data_o    = cap_data;
   assign ack_tgl_o = seen;

   // one request toggle yields exactly one landing strobe
   assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
endmodule

// File: rtl/lpw_bridge.sv
module lpw_bridge
   import lpw_pkg::*;
#(
   parameter int                ADDR_W      = 4,
   parameter int                DATA_W      = 32,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] STAT_ADDR   = 5,
   parameter logic [ADDR_W-1:0] IEN_ADDR    = 6
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic              lp_clk,
   input  logic              lp_rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              viol_i,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   output logic              sink_valid,
   output logic [ADDR_W-1:0] sink_addr,
   output logic [DATA_W-1:0] sink_data
);
   generate
      if (DATA_W < STAT_MIN_W) begin : g_bad_width
         $error("lpw_bridge: DATA_W too narrow for the status word");
      end
      if (STAT_ADDR == IEN_ADDR) begin : g_bad_map
         $error("lpw_bridge: status and enable addresses collide");
      end
   endgenerate

   // ---------------- decode ----------------
   logic hit_ien, hit_stat;
   logic ien_wr, xfer_wr, launch, drop, stat_rd;

   assign hit_ien  = (addr == IEN_ADDR);
   assign hit_stat = (addr == STAT_ADDR);
   assign ien_wr   = wr_en && hit_ien;
   assign xfer_wr  = wr_en && !hit_ien;
   assign stat_rd  = rd_en && hit_stat;

   // ---------------- crossing ----------------
   logic              req_tgl, ack_tgl, src_busy, done;
   logic [ADDR_W-1:0] x_addr;
   logic [DATA_W-1:0] x_data;
   logic              pend;

   assign launch = xfer_wr && !pend;
   assign drop   = xfer_wr && pend;

   lpw_src #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_src (
      .clk       (bus_clk),
      .rst_n     (bus_rst_n),
      .launch    (launch),
      .addr_in   (addr),
      .data_in   (wdata),
      .ack_tgl_i (ack_tgl),
      .req_tgl_o (req_tgl),
      .addr_o    (x_addr),
      .data_o    (x_data),
      .busy_o    (src_busy),
      .done_o    (done)
   );

   lpw_dst #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_dst (
      .clk       (lp_clk),
      .rst_n     (lp_rst_n),
      .req_tgl_i (req_tgl),
      .addr_i    (x_addr),
      .data_i    (x_data),
      .valid_o   (sink_valid),
      .addr_o    (sink_addr),
      .data_o    (sink_data),
      .ack_tgl_o (ack_tgl)
   );

   // ---------------- flags ----------------
   clr_mask_t pend_clr;
   logic wcf, wef, nvf, svf;
   logic ien_wn, ien_wc, ien_we;

   always_ff @(posedge bus_clk) begin
      if (!bus_rst_n) begin
         pend     <= 1'b0;
         pend_clr <= '0;
         wcf      <= 1'b0;
         wef      <= 1'b0;
         nvf      <= 1'b1;
         svf      <= 1'b0;
         ien_wn   <= 1'b0;
         ien_wc   <= 1'b0;
         ien_we   <= 1'b0;
      end else begin
         if (launch) begin
            pend         <= 1'b1;
            pend_clr.wef <= hit_stat && wdata[BIT_WEF];
            pend_clr.nvf <= hit_stat && wdata[BIT_NVF];
            pend_clr.svf <= hit_stat && wdata[BIT_SVF];
         end else if (done) begin
            pend <= 1'b0;
         end

         // completion wins over a same-cycle read
         if (done)         wcf <= 1'b1;
         else if (stat_rd) wcf <= 1'b0;

         // a collision wins over a same-cycle clear
         if (drop)                      wef <= 1'b1;
         else if (done && pend_clr.wef) wef <= 1'b0;

         if (done && pend_clr.nvf) nvf <= 1'b0;

         if (viol_i)                    svf <= 1'b1;
         else if (done && pend_clr.svf) svf <= 1'b0;

         if (ien_wr) begin
            ien_wn <= wdata[BIT_WNF];
            ien_wc <= wdata[BIT_WCF];
            ien_we <= wdata[BIT_WEF];
         end
      end
   end

   // ---------------- read path ----------------
   logic [DATA_W-1:0] stat_word, ien_word;

   always_comb begin
      stat_word          = '0;
      stat_word[BIT_WBF] = pend;
      stat_word[BIT_WNF] = !pend;
      stat_word[BIT_WCF] = wcf;
      stat_word[BIT_WEF] = wef;
      stat_word[BIT_ALM] = 1'b0;
      stat_word[BIT_NVF] = nvf;
      stat_word[BIT_SVF] = svf;
      ien_word           = '0;
      ien_word[BIT_WNF]  = ien_wn;
      ien_word[BIT_WCF]  = ien_wc;
      ien_word[BIT_WEF]  = ien_we;
   end

   always_ff @(posedge bus_clk) begin
      if (!bus_rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         if (hit_stat)     rdata <= stat_word;
         else if (hit_ien) rdata <= ien_word;
         else              rdata <= '0;
      end
   end

   assign irq = (ien_wc && (wcf || wef)) || (ien_we && wef) || (ien_wn && !pend);

   // ---------------- checks ----------------
   assert_drop_sets_err_R6: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (wr_en && !hit_ien && pend) |=> wef);

   assert_wcf_after_ack_R3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      $rose(wcf) |-> $past(done));

   assert_rd_clears_wcf_R4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (stat_rd && !done) |=> !wcf);

   assert_done_beats_rd_R4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (stat_rd && done) |=> wcf);

   assert_busy_tracks_src_R3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      src_busy |-> pend);
endmodule

// File: tb/lpw_bridge_tb_top.sv
module lpw_bridge_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int LP_PERIOD  = 74;
   localparam logic [3:0] STAT = 4'd5;
   localparam logic [3:0] IEN  = 4'd6;

   logic        bus_clk = 0, lp_clk = 0;
   logic        bus_rst_n = 0, lp_rst_n = 0;
   logic        wr_en = 0, rd_en = 0, viol_i = 0;
   logic [3:0]  addr = 0;
   logic [31:0] wdata = 0;
   logic [31:0] rdata;
   logic        irq, sink_valid;
   logic [3:0]  sink_addr;
   logic [31:0] sink_data;

   int checks = 0;
   int errors = 0;
   logic [35:0] exp_q[$];

   always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
   always #(LP_PERIOD/2)  lp_clk  = ~lp_clk;

   lpw_bridge dut_i (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .lp_clk(lp_clk), .lp_rst_n(lp_rst_n),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .viol_i(viol_i),
      .rdata(rdata), .irq(irq), .sink_valid(sink_valid),
      .sink_addr(sink_addr), .sink_data(sink_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // driver: pushes the expected landing item, then drives the write
   task automatic bus_write(input logic [3:0] a, input logic [31:0] d, input bit lands);
      if (lands) exp_q.push_back({a, d});
      @(negedge bus_clk);
      wr_en = 1; addr = a; wdata = d;
      @(negedge bus_clk);
      wr_en = 0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge bus_clk);
      rd_en = 1; addr = a;
      @(negedge bus_clk);
      rd_en = 0;
      d = rdata;
   endtask

   task automatic wait_idle(output logic [31:0] st);
      st = 32'h400;
      for (int i = 0; i < 300; i++) begin
         bus_read(STAT, st);
         if (!st[10]) break;
      end
   endtask

   // monitor: pops and compares each landing in the slow domain
   always @(negedge lp_clk) begin
      if (lp_rst_n && sink_valid) begin
         if (exp_q.size() == 0) begin
            chk("R2 unexpected sink strobe", {28'd0, sink_addr}, 32'hFFFF_FFFF);
         end else begin
            logic [35:0] e;
            e = exp_q.pop_front();
            chk("R2 sink addr", {28'd0, sink_addr}, {28'd0, e[35:32]});
            chk("R2 sink data", sink_data, e[31:0]);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge bus_clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] st;
      logic [31:0] rv;
      repeat (4) @(posedge lp_clk);
      @(negedge bus_clk);
      bus_rst_n = 1; lp_rst_n = 1;

      // R1 reset state
      bus_read(STAT, st);
      chk("R1 status after reset", st, 32'h202);
      bus_read(IEN, rv);
      chk("R1 enables after reset", rv, 32'h0);
      chk("R1 irq after reset", {31'd0, irq}, 32'd0);

      // R2/R3/R4 basic transfer
      bus_write(4'd2, 32'hA5A5_0001, 1);
      bus_read(STAT, st);
      chk("R3 busy while pending", {30'd0, st[10], st[9]}, 32'h2);
      wait_idle(st);
      chk("R3 complete after ack", {29'd0, st[10], st[9], st[8]}, 32'h3);
      bus_read(STAT, st);
      chk("R4 read clears complete", {31'd0, st[8]}, 32'd0);

      // R5 enable write is immediate and sets no completion
      bus_write(IEN, 32'h100, 0);
      bus_read(IEN, rv);
      chk("R5 enable readback", rv, 32'h100);
      repeat (60) @(negedge bus_clk);
      bus_read(STAT, st);
      chk("R5 no completion from enable write", {31'd0, st[8]}, 32'd0);
      chk("R9 irq low with flags clear", {31'd0, irq}, 32'd0);

      // R9 completion interrupt
      bus_write(4'd3, 32'h0000_1234, 1);
      repeat (80) @(negedge bus_clk);
      chk("R9 irq on completion", {31'd0, irq}, 32'd1);
      bus_read(STAT, st);
      @(negedge bus_clk);
      chk("R9 irq drops after status read", {31'd0, irq}, 32'd0);

      // R6 collision while busy, R5 enable write during busy
      bus_write(4'd3, 32'hCAFE_0003, 1);
      bus_write(4'd4, 32'hDEAD_0004, 0);
      bus_write(IEN, 32'h080, 0);
      bus_read(IEN, rv);
      chk("R5 enable accepted while busy", rv, 32'h080);
      wait_idle(st);
      chk("R6 error set by collision", {31'd0, st[7]}, 32'd1);
      chk("R9 irq on error enable", {31'd0, irq}, 32'd1);

      // R7 error is sticky across an unrelated write
      bus_write(4'd7, 32'h0000_0077, 1);
      wait_idle(st);
      chk("R7 error stays after other write", {31'd0, st[7]}, 32'd1);
      bus_write(STAT, 32'h080, 1);
      bus_read(STAT, st);
      chk("R7 error held until clear lands", {31'd0, st[7]}, 32'd1);
      wait_idle(st);
      chk("R7 error cleared by status write", {31'd0, st[7]}, 32'd0);
      chk("R9 irq low after error cleared", {31'd0, irq}, 32'd0);

      // R8 validity flags
      @(negedge bus_clk); viol_i = 1;
      @(negedge bus_clk); viol_i = 0;
      bus_read(STAT, st);
      chk("R8 violation sets flag", {30'd0, st[1], st[0]}, 32'h3);
      bus_write(STAT, 32'h003, 1);
      wait_idle(st);
      chk("R8 validity flags cleared", {30'd0, st[1], st[0]}, 32'h0);

      // R9 write-next interrupt when idle
      bus_write(IEN, 32'h200, 0);
      chk("R9 irq on write-next enable", {31'd0, irq}, 32'd1);

      repeat (10) @(negedge lp_clk);
      chk("R2 all expected writes landed", exp_q.size(), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule